// File: doc/BRIEF.md
# Serial Transmitter with Automatic Modem Flow Control

This block sends bytes as asynchronous serial frames. A byte comes in over a ready/valid write port and waits in a one-entry holding register. When the shifter is free, the byte moves into the shifter and goes out on the line as a frame. All bit timing comes from an external bit-rate tick. The block does not divide the system clock itself.

Two optional flow-control features are included. The first is clear-to-send gating. When it is enabled, the block checks the CTS input only when a new character is about to begin, so a character that has already started always finishes. The second is automatic ready-to-send release. Software raises RTS with a one-cycle set pulse. Once the transmitter has nothing left to send, and one further bit time has passed, the block lowers RTS by itself. If the receiver side is also set up to control RTS, that setting is not allowed, and automatic release is switched off. A channel-mode input decides how the transmit line and the receive line are routed. The four choices are normal operation, automatic echo, local loop-back and remote loop-back.

Top module: `uart_tx_flow`

## Requirements
- R1: After reset, txd is high, wr_ready is 1 and rts is 0.
- R2: Each frame is one low start bit, then the 8 data bits with the LSB first, then one high stop bit. Each bit lasts 16 baud_tick pulses. The line is high whenever no frame is being sent.
- R3: A write is taken in a cycle where wr_valid and wr_ready are both 1. wr_ready is 0 while the holding register is full. A byte that is waiting starts on the tick that ends the previous stop bit, so back-to-back frames have no idle gap.
- R4: With auto_cts_en at 1, a character starts only if cts is 1 on the tick where a start is possible. Otherwise txd stays high and the byte keeps waiting.
- R5: A change of cts after a character has started does not change that character.
- R6: With auto_cts_en at 0, cts has no effect.
- R7: With auto_rts_en at 1 and rx_rts_en at 0, rts falls on the 16th baud_tick counted while the holding register and the shifter are both empty and no write is being taken.
- R8: A byte written before that count completes stops the release. This includes a write in the same cycle as the 16th tick.
- R9: With auto_rts_en at 0, or with auto_rts_en and rx_rts_en both at 1, the transmitter never clears rts.
- R10: A pulse on rts_set makes rts 1 in the next cycle. The set wins over an automatic release that falls in the same cycle.
- R11: The channel mode is encoded as follows. In every mode the transmitter logic keeps running.

| chan_mode | Mode | txd | rx_path |
|---|---|---|---|
| 00 | normal | transmitter output | rxd |
| 01 | automatic echo | rxd | rxd |
| 10 | local loop-back | held high | transmitter output |
| 11 | remote loop-back | rxd | held high |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_data | input | 8 | Byte to send |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Holding register is empty |
| baud_tick | input | 1 | Bit-rate tick, 16 per bit |
| cts | input | 1 | Clear-to-send, 1 means asserted |
| auto_cts_en | input | 1 | Enables clear-to-send gating |
| auto_rts_en | input | 1 | Enables automatic ready-to-send release |
| rx_rts_en | input | 1 | Receiver side is configured for RTS control |
| rts_set | input | 1 | Software set pulse for RTS |
| rts | output | 1 | Ready-to-send, 1 means asserted |
| chan_mode | input | 2 | Channel routing mode |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rx_path | output | 1 | Line that feeds the local receiver |

## Verification
Two coincidences are provoked on purpose. The bench waits until the release counter is one tick from expiry. At that point it either writes a byte or pulses rts_set, timed so that the action lands on the expiring tick itself. In both cases rts must stay high. The other coincidence is a waiting byte being handed over on the tick that ends the stop bit. There the start bit must follow with no gap. A behavioural reference model is compared with the outputs on every cycle, so an off-by-one cycle in either case shows up as a FAIL.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;
    typedef enum logic [1:0] {
        CH_NORMAL = 2'b00,
        CH_ECHO   = 2'b01,
        CH_LOCAL  = 2'b10,
        CH_REMOTE = 2'b11
    } chan_mode_e;
endpackage

// File: rtl/uart_txc.sv
// Holding register plus frame shifter. The shifter only loads on a tick.
module uart_txc #(
    parameter int DATA_BITS     = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic                 wr_valid,
    output logic                 wr_ready,
    input  logic                 baud_tick,
    input  logic                 start_ok,
    output logic                 line,
    output logic                 drained
);
    localparam int FRAME_BITS = DATA_BITS + 2;
    localparam int BW = $clog2(FRAME_BITS);
    localparam int SW = $clog2(TICKS_PER_BIT);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);
    localparam logic [SW-1:0] LAST_SUB = SW'(TICKS_PER_BIT - 1);

    typedef struct packed {
        logic                 hold_vld;
        logic [DATA_BITS-1:0] hold;
        logic                 busy;
        logic [DATA_BITS-1:0] shreg;
        logic [BW-1:0]        bitn;
        logic [SW-1:0]        sub;
    } txc_state_t;

    txc_state_t s_d, s_q;
    logic accept, at_end;

    always_comb begin
        s_d    = s_q;
        accept = wr_valid && !s_q.hold_vld;
        at_end = s_q.busy && (s_q.bitn == LAST_BIT) && (s_q.sub == LAST_SUB);
        if (baud_tick) begin
            if (!s_q.busy || at_end) begin
                if (s_q.hold_vld && start_ok) begin
                    s_d.busy     = 1'b1;
                    s_d.shreg    = s_q.hold;
                    s_d.bitn     = '0;
                    s_d.sub      = '0;
                    s_d.hold_vld = 1'b0;
                end else begin
                    s_d.busy = 1'b0;
                end
            end else if (s_q.sub == LAST_SUB) begin
                s_d.sub  = '0;
                s_d.bitn = s_q.bitn + BW'(1);
                if (s_q.bitn != '0) s_d.shreg = s_q.shreg >> 1;
            end else begin
                s_d.sub = s_q.sub + SW'(1);
            end
        end
        if (accept) begin
            s_d.hold_vld = 1'b1;
            s_d.hold     = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_ready = !s_q.hold_vld;
    assign drained  = !s_q.busy && !s_q.hold_vld && !accept;
    assign line     = !s_q.busy            ? 1'b1 :
                      (s_q.bitn == '0)     ? 1'b0 :
                      (s_q.bitn == LAST_BIT) ? 1'b1 : s_q.shreg[0];
endmodule

// File: rtl/uart_rts_ctl.sv
// RTS flop: software set, automatic release one bit time after drain.
module uart_rts_ctl #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_tick,
    input  logic rts_set,
    input  logic auto_ok,
    input  logic drained,
    output logic rts
);
    localparam int SW = $clog2(TICKS_PER_BIT);
    localparam logic [SW-1:0] LAST_SUB = SW'(TICKS_PER_BIT - 1);

    typedef struct packed {
        logic          rts;
        logic [SW-1:0] cnt;
    } rts_state_t;

    rts_state_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!auto_ok || !drained || !r_q.rts) begin
            r_d.cnt = '0;
        end else if (baud_tick) begin
            if (r_q.cnt == LAST_SUB) begin
                r_d.rts = 1'b0;
                r_d.cnt = '0;
            end else begin
                r_d.cnt = r_q.cnt + SW'(1);
            end
        end
        if (rts_set) r_d.rts = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rts = r_q.rts;
endmodule

// File: rtl/uart_chan_route.sv
module uart_chan_route
    import uart_flow_pkg::*;
(
    input  logic [1:0] chan_mode,
    input  logic       tx_line,
    input  logic       rxd,
    output logic       txd,
    output logic       rx_path
);
    chan_mode_e mode;

    always_comb begin
        mode = chan_mode_e'(chan_mode);
        unique case (mode)
            CH_NORMAL: begin txd = tx_line; rx_path = rxd;     end
            CH_ECHO:   begin txd = rxd;     rx_path = rxd;     end
            CH_LOCAL:  begin txd = 1'b1;    rx_path = tx_line; end
            default:   begin txd = rxd;     rx_path = 1'b1;    end
        endcase
    end
endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow #(
    parameter int DATA_BITS     = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic                 wr_valid,
    output logic                 wr_ready,
    input  logic                 baud_tick,
    input  logic                 cts,
    input  logic                 auto_cts_en,
    input  logic                 auto_rts_en,
    input  logic                 rx_rts_en,
    input  logic                 rts_set,
    output logic                 rts,
    input  logic [1:0]           chan_mode,
    input  logic                 rxd,
    output logic                 txd,
    output logic                 rx_path
);
    logic start_ok, auto_ok, tx_line, drained;

    assign start_ok = !auto_cts_en || cts;
    // Both sides claiming RTS is illegal: automatic release is disabled.
    assign auto_ok  = auto_rts_en && !rx_rts_en;

    uart_txc #(.DATA_BITS(DATA_BITS), .TICKS_PER_BIT(TICKS_PER_BIT)) u_txc (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .baud_tick(baud_tick), .start_ok(start_ok),
        .line(tx_line), .drained(drained)
    );

    uart_rts_ctl #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_rts (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rts_set(rts_set),
        .auto_ok(auto_ok), .drained(drained), .rts(rts)
    );

    uart_chan_route u_route (
        .chan_mode(chan_mode), .tx_line(tx_line), .rxd(rxd),
        .txd(txd), .rx_path(rx_path)
    );
endmodule

// File: rtl/uart_flow_chk.sv
module uart_flow_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_valid,
    input logic       wr_ready,
    input logic       baud_tick,
    input logic       rts_set,
    input logic       auto_rts_en,
    input logic       rx_rts_en,
    input logic       rts,
    input logic [1:0] chan_mode,
    input logic       rxd,
    input logic       txd,
    input logic       rx_path
);
    a_r3_full_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !wr_ready);
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rts_set |=> rts);
    a_r9_no_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rts && (!auto_rts_en || rx_rts_en)) |=> rts);
    a_r7_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rts) |-> $past(baud_tick));
    a_r11_local_pin_high: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_mode == 2'b10) |-> txd);
    a_r11_echo_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_mode == 2'b01) |-> (txd == rxd && rx_path == rxd));
    a_r11_remote_rx_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_mode == 2'b11) |-> (rx_path && txd == rxd));
endmodule

bind uart_tx_flow uart_flow_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .baud_tick(baud_tick), .rts_set(rts_set), .auto_rts_en(auto_rts_en),
    .rx_rts_en(rx_rts_en), .rts(rts), .chan_mode(chan_mode), .rxd(rxd),
    .txd(txd), .rx_path(rx_path)
);

// File: tb/uart_tx_flow_test.sv
`timescale 1ns/1ps
module uart_tx_flow_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_valid = 1'b0, baud_tick = 1'b0, cts = 1'b0;
    logic       auto_cts_en = 1'b0, auto_rts_en = 1'b0, rx_rts_en = 1'b0;
    logic       rts_set = 1'b0, rxd = 1'b1;
    logic [1:0] chan_mode = 2'b00;
    logic       wr_ready, rts, txd, rx_path;

    int n_checks = 0, n_fail = 0, cyc = 0;
    string cur_req = "R1";

    // reference model state
    int m_hv = 0, m_hold = 0, m_busy = 0, m_pos = 0, m_byte = 0;
    int m_rts = 0, m_rc = 0, m_acc = 0;

    always #2.5 clk = ~clk;

    uart_tx_flow uut (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .baud_tick(baud_tick), .cts(cts),
        .auto_cts_en(auto_cts_en), .auto_rts_en(auto_rts_en),
        .rx_rts_en(rx_rts_en), .rts_set(rts_set), .rts(rts),
        .chan_mode(chan_mode), .rxd(rxd), .txd(txd), .rx_path(rx_path)
    );

    always @(posedge clk) begin
        int acc, gate, drn, au, nrts, nrc, nhv;
        if (!rst_n) begin
            m_hv = 0; m_busy = 0; m_pos = 0; m_rts = 0; m_rc = 0; m_acc = 0;
        end else begin
            acc  = (wr_valid && m_hv == 0) ? 1 : 0;
            gate = (!auto_cts_en || cts) ? 1 : 0;
            drn  = (m_busy == 0 && m_hv == 0 && acc == 0) ? 1 : 0;
            au   = (auto_rts_en && !rx_rts_en) ? 1 : 0;
            nrts = m_rts; nrc = m_rc; nhv = m_hv;
            if (au == 0 || drn == 0 || m_rts == 0) nrc = 0;
            else if (baud_tick) begin
                if (m_rc == 15) begin nrts = 0; nrc = 0; end
                else nrc = m_rc + 1;
            end
            if (rts_set) nrts = 1;
            if (baud_tick) begin
                if (m_busy == 0 || m_pos == 159) begin
                    if (m_hv == 1 && gate == 1) begin
                        m_busy = 1; m_pos = 0; m_byte = m_hold; nhv = 0;
                    end else m_busy = 0;
                end else m_pos = m_pos + 1;
            end
            if (acc == 1) begin nhv = 1; m_hold = int'(wr_data); end
            m_hv = nhv; m_rts = nrts; m_rc = nrc; m_acc = acc;
        end
    end

    function automatic logic exp_line();
        int b;
        if (m_busy == 0) return 1'b1;
        b = m_pos / 16;
        if (b == 0) return 1'b0;
        if (b == 9) return 1'b1;
        return logic'((m_byte >> (b - 1)) & 1);
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    task automatic compare();
        logic l, et, er;
        l = exp_line();
        case (chan_mode)
            2'b00: begin et = l;    er = rxd;  end
            2'b01: begin et = rxd;  er = rxd;  end
            2'b10: begin et = 1'b1; er = l;    end
            default: begin et = rxd; er = 1'b1; end
        endcase
        chk(cur_req, "txd", txd, et);
        chk(cur_req, "rx_path", rx_path, er);
        chk(cur_req, "wr_ready", wr_ready, logic'(m_hv == 0));
        chk(cur_req, "rts", rts, logic'(m_rts == 1));
    endtask

    // one clock: model and DUT update at posedge, compare at negedge, then drive next tick
    task automatic cycle(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
            compare();
            baud_tick = (cyc % 2 == 0);
        end
    endtask

    task automatic send(input logic [7:0] b);
        wr_data = b; wr_valid = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            cycle();
            if (m_acc == 1) break;
        end
        wr_valid = 1'b0;
    endtask

    task automatic pulse_set();
        rts_set = 1'b1; cycle(); rts_set = 1'b0;
    endtask

    // stop when the next edge carries the 16th drained tick
    task automatic wait_expiry();
        for (int i = 0; i < 4000; i++) begin
            if (m_rc == 15 && baud_tick) break;
            cycle();
        end
    endtask

    always @(negedge clk) begin
        if (cyc > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk("R1", "txd", txd, 1'b1);
        chk("R1", "wr_ready", wr_ready, 1'b1);
        chk("R1", "rts", rts, 1'b0);
        rst_n = 1'b1;
        cycle(4);

        cur_req = "R2";
        send(8'hA5); cycle(340);

        cur_req = "R3";
        send(8'h3C); send(8'hC3);
        chk("R3", "wr_ready while full", wr_ready, 1'b0);
        send(8'h96);
        cycle(700);

        cur_req = "R4";
        auto_cts_en = 1'b1; cts = 1'b0;
        send(8'h55); cycle(120);
        chk("R4", "txd held idle", txd, 1'b1);
        chk("R4", "byte still waiting", wr_ready, 1'b0);
        cts = 1'b1; cycle(340);

        cur_req = "R5";
        send(8'h0F); cycle(40); cts = 1'b0; cycle(300);
        chk("R5", "frame finished", wr_ready, 1'b1);
        cts = 1'b1;

        cur_req = "R6";
        auto_cts_en = 1'b0; cts = 1'b0;
        send(8'h81); cycle(340);
        cts = 1'b1;

        cur_req = "R7";
        auto_rts_en = 1'b1;
        pulse_set();
        send(8'h7E); cycle(360);
        chk("R7", "rts released", rts, 1'b0);

        cur_req = "R8";
        pulse_set(); wait_expiry();
        send(8'h42);
        chk("R8", "rts kept on write at expiry", rts, 1'b1);
        cycle(380);
        chk("R8", "rts released later", rts, 1'b0);

        cur_req = "R10";
        pulse_set(); wait_expiry();
        pulse_set();
        chk("R10", "set beats release", rts, 1'b1);
        cycle(40);

        cur_req = "R9";
        rx_rts_en = 1'b1; pulse_set(); send(8'h11); cycle(400);
        chk("R9", "rts kept, illegal combo", rts, 1'b1);
        rx_rts_en = 1'b0; auto_rts_en = 1'b0; cycle(100);
        chk("R9", "rts kept, release off", rts, 1'b1);

        cur_req = "R11";
        for (int md = 0; md < 4; md++) begin
            chan_mode = 2'(md);
            send(8'hC9);
            for (int k = 0; k < 170; k++) begin
                rxd = logic'((k / 3) % 2);
                cycle();
            end
            rxd = 1'b1; cycle(200);
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule